// File: doc/BRIEF.md
# ISA Card I/O and Option-ROM Window Decoder

This block watches the address and command strobes of an 8-bit ISA expansion slot and produces two selects. The first covers a window of sixteen consecutive I/O ports. The second covers an 8 KB memory window that holds the card's option ROM. Each window has a base that can be moved by four jumper inputs. All other base bits are wired in, so each window can sit at one of sixteen fixed places.

The I/O window always lies between 0x100 and 0x1FF. Address bits 7..4 pick one of the sixteen 16-port slots, and bits 3..0 are passed out as the register offset. The ROM window always lies in the upper part of the 1 MB space. Bits 19 and 18 are high, bit 13 is low, and bits 17..14 come from the jumpers, which gives 8 KB windows at 0xC0000, 0xC4000, and so on up to 0xFC000.

A fitted jumper pulls its input low, and an open jumper is read as high through a pull-up, so each jumper input carries the address bit it stands for directly. The selects are gated by the active-low command strobes and by AEN. They are registered, so each result appears one clock after the bus state that caused it.

Top module: `isa_win_decode`

## Requirements
- R1: While `rst` is high at a clock edge, `io_sel`, `io_reg` and `rom_cs` are all 0 after that edge, whatever the bus inputs are.
- R2: `io_sel` is 1 one cycle after a cycle in which `bus_addr[7:4]` equals `io_jmp`, `bus_addr[9:8]` is 2'b01, `aen` is 0 and a strobe is active; with `io_jmp` at 0 the slot starts at 0x100, and with 4'hF it starts at 0x1F0.
- R3: When `io_sel` is 1, `io_reg` equals `bus_addr[3:0]` from the previous cycle; when `io_sel` is 0, `io_reg` is 0.
- R4: The I/O select requires `ior_n` or `iow_n` to be low (active low). With both high, `io_sel` stays 0 even for a matching address.
- R5: While `aen` is 1, neither `io_sel` nor `rom_cs` is raised.
- R6: Only `bus_addr[9:0]` takes part in the I/O decode. `bus_addr[9:8]` other than 2'b01 never hits the window, and bits 19..10 have no effect on it.
- R7: `rom_cs` is 1 one cycle after a cycle in which `bus_addr[19:18]` is 2'b11, `bus_addr[13]` is 0, `bus_addr[17:14]` equals `rom_jmp`, `memr_n` is low and `aen` is 0. Offsets 0x0000 through 0x1FFF inside the window all hit.
- R8: An address whose bit 13 is 1 (the upper 8 KB of a 16 KB slot, for example 0xC2000) never raises `rom_cs`.
- R9: `rom_cs` requires `memr_n` low. Memory writes never raise it, and neither do the I/O strobes.
- R10: Jumper inputs are taken as plain address bits, with a fitted jumper giving 0 and an open one giving 1. With all jumpers open, the windows are at 0x1F0 and 0xFC000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 20 | ISA address bus A19..A0 |
| aen | input | 1 | Address enable, high during DMA cycles |
| ior_n | input | 1 | I/O read strobe, active low |
| iow_n | input | 1 | I/O write strobe, active low |
| memr_n | input | 1 | Memory read strobe, active low |
| io_jmp | input | 4 | I/O base jumpers for A7..A4, fitted = 0 |
| rom_jmp | input | 4 | ROM base jumpers for A17..A14, fitted = 0 |
| io_sel | output | 1 | I/O window select, registered |
| io_reg | output | 4 | Register offset A3..A0, registered |
| rom_cs | output | 1 | Option ROM chip select, registered |

## Verification
All three outputs have exactly one register between the bus inputs and the output, so each result is due on the clock edge that follows the cycle in which the stimulus was driven. The driver applies each bus state on a falling edge and queues the expected `io_sel`, `io_reg` and `rom_cs` for it. The monitor pops one queued item a moment after the next rising edge and compares it, which keeps every comparison locked to the single cycle of latency. The embedded assertions check the same one-cycle relation by using `$past` of the inputs against the current outputs.

// File: rtl/isa_dec_pkg.sv
package isa_dec_pkg;
  localparam int IO_ADDR_W  = 10;
  localparam int IO_OFS_W   = 4;
  localparam int MEM_ADDR_W = 20;
  localparam int ROM_OFS_W  = 13;
  localparam int ROM_PAD_W  = 1;
  localparam int JMP_W      = 4;
endpackage

// File: rtl/isa_win_match.sv
// Compares the upper part of an address against a hard-wired prefix,
// a jumper field and an optional zero gap just above the window offset.
module isa_win_match #(
  parameter int HI_W    = 6,
  parameter int PAD_W   = 0,
  parameter int JMP_W   = 4,
  parameter int FIX_VAL = 1
) (
  input  logic [HI_W-1:0]  addr_hi,
  input  logic [JMP_W-1:0] jmp,
  output logic             hit
);
  localparam int JMP_LO = PAD_W;
  localparam int FIX_LO = PAD_W + JMP_W;
  localparam int FIX_W  = HI_W - FIX_LO;

  logic fix_ok, jmp_ok, pad_ok;

  assign fix_ok = (addr_hi[HI_W-1:FIX_LO] == FIX_W'(FIX_VAL));
  assign jmp_ok = (addr_hi[FIX_LO-1:JMP_LO] == jmp);

  generate
    if (PAD_W > 0) begin : g_pad
      assign pad_ok = (addr_hi[PAD_W-1:0] == '0);
    end else begin : g_nopad
      assign pad_ok = 1'b1;
    end
  endgenerate

  assign hit = fix_ok & jmp_ok & pad_ok;
endmodule

// File: rtl/isa_sel_reg.sv
module isa_sel_reg #(
  parameter int OFS_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             io_hit,
  input  logic [OFS_W-1:0] io_ofs,
  input  logic             rom_hit,
  output logic             io_sel,
  output logic [OFS_W-1:0] io_reg,
  output logic             rom_cs
);
  always_ff @(posedge clk) begin
    if (rst) begin
      io_sel <= 1'b0;
      io_reg <= '0;
      rom_cs <= 1'b0;
    end else begin
      io_sel <= io_hit;
      io_reg <= io_hit ? io_ofs : '0;
      rom_cs <= rom_hit;
    end
  end
endmodule

// File: rtl/isa_win_decode.sv
module isa_win_decode
  import isa_dec_pkg::*;
#(
  parameter int IOA_W = IO_ADDR_W,
  parameter int IOO_W = IO_OFS_W,
  parameter int MA_W  = MEM_ADDR_W,
  parameter int RO_W  = ROM_OFS_W,
  parameter int RP_W  = ROM_PAD_W,
  parameter int J_W   = JMP_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [MA_W-1:0]  bus_addr,
  input  logic             aen,
  input  logic             ior_n,
  input  logic             iow_n,
  input  logic             memr_n,
  input  logic [J_W-1:0]   io_jmp,
  input  logic [J_W-1:0]   rom_jmp,
  output logic             io_sel,
  output logic [IOO_W-1:0] io_reg,
  output logic             rom_cs
);
  localparam int IO_HI_W  = IOA_W - IOO_W;
  localparam int ROM_HI_W = MA_W - RO_W;
  localparam int IO_FIX_W = IO_HI_W - J_W;
  localparam int RM_FIX_W = ROM_HI_W - J_W - RP_W;
  localparam int IO_FIX   = 1;
  localparam int RM_FIX   = (1 << RM_FIX_W) - 1;

  logic io_addr_hit, rom_addr_hit, io_cyc, rom_cyc;

  assign io_cyc  = ~aen & (~ior_n | ~iow_n);
  assign rom_cyc = ~aen & ~memr_n;

  isa_win_match #(.HI_W(IO_HI_W), .PAD_W(0), .JMP_W(J_W), .FIX_VAL(IO_FIX)) u_io_match (
    .addr_hi (bus_addr[IOA_W-1:IOO_W]),
    .jmp     (io_jmp),
    .hit     (io_addr_hit)
  );

  isa_win_match #(.HI_W(ROM_HI_W), .PAD_W(RP_W), .JMP_W(J_W), .FIX_VAL(RM_FIX)) u_rom_match (
    .addr_hi (bus_addr[MA_W-1:RO_W]),
    .jmp     (rom_jmp),
    .hit     (rom_addr_hit)
  );

  isa_sel_reg #(.OFS_W(IOO_W)) u_out (
    .clk     (clk),
    .rst     (rst),
    .io_hit  (io_addr_hit & io_cyc),
    .io_ofs  (bus_addr[IOO_W-1:0]),
    .rom_hit (rom_addr_hit & rom_cyc),
    .io_sel  (io_sel),
    .io_reg  (io_reg),
    .rom_cs  (rom_cs)
  );

  // Assertions
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!io_sel && !rom_cs && io_reg == '0));
  assert_io_base_R2: assert property (@(posedge clk) disable iff (rst)
    io_sel |-> $past(bus_addr[IOO_W+J_W-1:IOO_W] == io_jmp));
  assert_io_offset_R3: assert property (@(posedge clk) disable iff (rst)
    io_sel |-> io_reg == $past(bus_addr[IOO_W-1:0]));
  assert_io_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    io_sel |-> $past(!ior_n || !iow_n));
  assert_no_dma_hit_R5: assert property (@(posedge clk) disable iff (rst)
    (io_sel || rom_cs) |-> !$past(aen));
  assert_io_range_R6: assert property (@(posedge clk) disable iff (rst)
    io_sel |-> $past(bus_addr[IOA_W-1:IOA_W-IO_FIX_W]) == IO_FIX_W'(IO_FIX));
  assert_rom_base_R7: assert property (@(posedge clk) disable iff (rst)
    rom_cs |-> $past(bus_addr[MA_W-RM_FIX_W-1:RO_W+RP_W] == rom_jmp));
  assert_rom_gap_R8: assert property (@(posedge clk) disable iff (rst)
    rom_cs |-> !$past(bus_addr[RO_W]));
  assert_rom_read_R9: assert property (@(posedge clk) disable iff (rst)
    rom_cs |-> !$past(memr_n));
endmodule

// File: tb/isa_win_decode_bench.sv
module isa_win_decode_bench;
  typedef struct {
    logic       io_sel;
    logic [3:0] io_reg;
    logic       rom_cs;
    string      req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [19:0] bus_addr = '0;
  logic        aen = 1'b0, ior_n = 1'b1, iow_n = 1'b1, memr_n = 1'b1;
  logic [3:0]  io_jmp = '0, rom_jmp = '0;
  logic        io_sel, rom_cs;
  logic [3:0]  io_reg;

  exp_t q[$];
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  isa_win_decode u_isa_win_decode (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .aen(aen), .ior_n(ior_n),
    .iow_n(iow_n), .memr_n(memr_n), .io_jmp(io_jmp), .rom_jmp(rom_jmp),
    .io_sel(io_sel), .io_reg(io_reg), .rom_cs(rom_cs)
  );

  // Driver: applies one bus state on a falling edge and queues the result
  // the requirements predict for the following rising edge.
  task automatic drive(input logic [19:0] a, input logic ae, input logic rn,
                       input logic wn, input logic mn, input logic [3:0] ij,
                       input logic [3:0] rj, input string req);
    exp_t e;
    logic io_hit;
    @(negedge clk);
    bus_addr = a; aen = ae; ior_n = rn; iow_n = wn; memr_n = mn;
    io_jmp = ij; rom_jmp = rj;
    io_hit = !ae && (!rn || !wn) && a[9:8] == 2'b01 && a[7:4] == ij;
    e.io_sel = rst ? 1'b0 : io_hit;
    e.io_reg = (rst || !io_hit) ? 4'h0 : a[3:0];
    e.rom_cs = rst ? 1'b0 : (!ae && !mn && a[19:18] == 2'b11 && !a[13] && a[17:14] == rj);
    e.req = req;
    q.push_back(e);
  endtask

  // Monitor: compares just after the edge that registers each stimulus.
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      total++;
      if (io_sel !== e.io_sel || io_reg !== e.io_reg || rom_cs !== e.rom_cs) begin
        bad++;
        $display("FAIL %s: got io_sel=%b io_reg=%h rom_cs=%b, expected io_sel=%b io_reg=%h rom_cs=%b",
                 e.req, io_sel, io_reg, rom_cs, e.io_sel, e.io_reg, e.rom_cs);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset holds outputs low even with hitting bus states
    drive(20'h00105, 0, 0, 1, 1, 4'h0, 4'h0, "R1");
    drive(20'hC0000, 0, 1, 1, 0, 4'h0, 4'h0, "R1");
    @(negedge clk); rst = 1'b0;
    // R2 R3 R10: all jumpers fitted -> base 0x100
    drive(20'h00105, 0, 0, 1, 1, 4'h0, 4'h0, "R2_R3_R10");
    // R2 R10: all open -> 0x1F0, write strobe
    drive(20'h001FA, 0, 1, 0, 1, 4'hF, 4'h0, "R2_R10");
    drive(20'h001A3, 0, 0, 1, 1, 4'hA, 4'h0, "R2");
    drive(20'h001B3, 0, 0, 1, 1, 4'hA, 4'h0, "R2");
    drive(20'h001A0, 0, 0, 1, 1, 4'hA, 4'h0, "R3");
    drive(20'h001AF, 0, 1, 0, 1, 4'hA, 4'h0, "R3");
    // R4: no strobe
    drive(20'h001A3, 0, 1, 1, 1, 4'hA, 4'h0, "R4");
    // R5: DMA cycle
    drive(20'h001A3, 1, 0, 1, 1, 4'hA, 4'h0, "R5");
    drive(20'hC4000, 1, 1, 1, 0, 4'h0, 4'h1, "R5");
    // R6: A9/A8 wrong, upper bits ignored
    drive(20'h003A3, 0, 0, 1, 1, 4'hA, 4'h0, "R6");
    drive(20'h000A3, 0, 0, 1, 1, 4'hA, 4'h0, "R6");
    drive(20'hFC1A3, 0, 0, 1, 1, 4'hA, 4'h0, "R6");
    // R7 R10: ROM windows
    drive(20'hC0000, 0, 1, 1, 0, 4'h0, 4'h0, "R7_R10");
    drive(20'hC1FFF, 0, 1, 1, 0, 4'h0, 4'h0, "R7");
    drive(20'hE4000, 0, 1, 1, 0, 4'h0, 4'h9, "R7");
    drive(20'hFC000, 0, 1, 1, 0, 4'h0, 4'hF, "R7_R10");
    drive(20'hFDFFF, 0, 1, 1, 0, 4'h0, 4'hF, "R7");
    drive(20'h80000, 0, 1, 1, 0, 4'h0, 4'h0, "R7");
    drive(20'hC4000, 0, 1, 1, 0, 4'h0, 4'h0, "R7");
    // R8: gap bit set
    drive(20'hC2000, 0, 1, 1, 0, 4'h0, 4'h0, "R8");
    drive(20'hFE000, 0, 1, 1, 0, 4'h0, 4'hF, "R8");
    // R9: no memory read / I/O strobes only
    drive(20'hC0010, 0, 1, 1, 1, 4'h0, 4'h0, "R9");
    drive(20'hC0010, 0, 0, 0, 1, 4'h0, 4'h0, "R9");
    // R1 again: reset in mid-run
    @(negedge clk); rst = 1'b1;
    drive(20'h001FA, 0, 0, 1, 1, 4'hF, 4'h0, "R1");
    @(negedge clk); rst = 1'b0; memr_n = 1'b1; ior_n = 1'b1;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule